// File: doc/BRIEF.md
# Interrupt Context Stacking Sequencer

This block saves and restores processor context around an interrupt. After the priority arbiter accepts a request, the sequencer writes a two-word frame to data memory at a software stack pointer. The frame holds the interrupted program counter, the status low byte, which carries the old priority level, and the trap-priority bit. The sequencer then presents the vector address and a status byte in which the priority field is raised to the accepted level. The core loads both, so every lower-priority request stays masked until the handler returns.

On a return request the sequencer reads the frame back in the reverse order. It then presents the original program counter, status byte and trap bit, so the core resumes exactly where it was interrupted. The stack grows toward higher byte addresses. A push writes at the pointer and then advances it by one word (2 bytes). A pop first moves the pointer back by one word and then reads. Frames nest, so interrupts can preempt each other to any depth that memory allows.

Top module: `irq_ctx_stacker`

## Requirements
- R1: After reset the block is idle (`busy`=0), asserts no strobe (`memWe`, `memRe`, `ctxLoad`, `done` all 0), and `spValue` equals the parameter `SP_INIT`.
- R2: When `entryReq` is high in an idle cycle, the next cycle writes `curPc[15:0]` to address `spValue`.
- R3: The cycle after that writes the word {`curStatus`[7:0] in bits 15:8, `trapIn` in bit 7, `curPc[22:16]` in bits 6:0} to the previous address plus 2.
- R4: A completed entry leaves `spValue` 4 higher than before. Each push writes at the pointer and then adds 2.
- R5: In the third cycle after acceptance, `ctxLoad` and `done` are high for exactly one cycle. `ctxPc` equals the captured `entryVector`. `ctxStatus` equals the captured status with bits 7:5 replaced by `entryLevel` and bits 4:0 unchanged. `ctxTrap` is 0.
- R6: When `retReq` (and not `entryReq`) is high in an idle cycle, the next cycle reads `spValue-2` and the cycle after reads `spValue-4`, so the pointer is moved back before each read. Read data returns one cycle after `memRe`.
- R7: In the third cycle after a return is accepted, `ctxLoad` and `done` pulse for one cycle, and `ctxPc`, `ctxStatus` and `ctxTrap` equal exactly the values stacked by the matching entry. Nested frames are restored last-in first-out.
- R8: `entryReq` and `retReq` have no effect while `busy` is high. No extra memory access, load or pointer change results from them.
- R9: If `entryReq` and `retReq` are both high in the same idle cycle, the entry sequence runs and the return request is dropped.
- R10: `memWe` and `memRe` are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| entryReq | input | 1 | Interrupt accepted by the arbiter |
| entryLevel | input | 3 | Priority level of the accepted interrupt |
| entryVector | input | 23 | Handler address for the accepted interrupt |
| retReq | input | 1 | Return-from-interrupt request |
| curPc | input | 23 | Program counter of the interrupted code |
| curStatus | input | 8 | Status low byte (priority in bits 7:5) |
| trapIn | input | 1 | Current trap-priority bit |
| memWe | output | 1 | Data memory write strobe |
| memRe | output | 1 | Data memory read strobe |
| memAddr | output | 16 | Byte address of the access |
| memWdata | output | 16 | Write data |
| memRdata | input | 16 | Read data, valid one cycle after `memRe` |
| spValue | output | 16 | Stack pointer register |
| ctxLoad | output | 1 | Load strobe for PC, status and trap bit |
| ctxPc | output | 23 | PC to load (vector or restored PC) |
| ctxStatus | output | 8 | Status byte to load |
| ctxTrap | output | 1 | Trap-priority bit to load |
| busy | output | 1 | A sequence is running |
| done | output | 1 | One-cycle pulse at the end of a sequence |

## Verification
Both sequences have fixed latency once a request lands in an idle cycle. The first memory access appears in the cycle after the accepting edge, the second one cycle later, and `ctxLoad` with `done` in the third cycle. The driver drives each request on a falling edge and computes the expected writes, reads and load values from its own copy of the stack pointer and frame stack. The monitor samples on each falling edge and pops one expected item for every strobe it sees, so an early, late, missing or extra access shows up as a mismatch. The driver also checks `done`, `busy` and `spValue` at the falling edges where the cycle count puts them.

// File: rtl/irq_ctx_pkg.sv
package irq_ctx_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_PUSH_LO,
    ST_PUSH_HI,
    ST_LOAD_VEC,
    ST_POP_HI,
    ST_POP_LO,
    ST_RESTORE
  } seq_state_t;

  // strobes from control to datapath
  typedef struct packed {
    logic capEntry;  // latch the entry context
    logic spInc;     // advance the pointer by one word
    logic spDec;     // move the pointer back by one word
    logic addrPre;   // address = pointer minus one word
    logic wrHi;      // write the packed upper frame word
    logic capHi;     // latch returning upper frame word
    logic restore;   // outputs come from the popped frame
    logic loadOut;   // present the load strobe
    logic memWe;
    logic memRe;
  } strobe_t;

endpackage

// File: rtl/irq_ctx_ctrl.sv
module irq_ctx_ctrl
  import irq_ctx_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    entryReq,
  input  logic    retReq,
  output strobe_t strobe,
  output logic    busy,
  output logic    done
);

  seq_state_t state, nextState;

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= nextState;
  end

  always_comb begin
    nextState = state;
    strobe    = '0;
    unique case (state)
      ST_IDLE: begin
        if (entryReq) begin
          nextState       = ST_PUSH_LO;
          strobe.capEntry = 1'b1;
        end else if (retReq) begin
          nextState = ST_POP_HI;
        end
      end
      ST_PUSH_LO: begin
        strobe.memWe = 1'b1;
        strobe.spInc = 1'b1;
        nextState    = ST_PUSH_HI;
      end
      ST_PUSH_HI: begin
        strobe.memWe = 1'b1;
        strobe.wrHi  = 1'b1;
        strobe.spInc = 1'b1;
        nextState    = ST_LOAD_VEC;
      end
      ST_LOAD_VEC: begin
        strobe.loadOut = 1'b1;
        nextState      = ST_IDLE;
      end
      ST_POP_HI: begin
        strobe.memRe   = 1'b1;
        strobe.addrPre = 1'b1;
        strobe.spDec   = 1'b1;
        nextState      = ST_POP_LO;
      end
      ST_POP_LO: begin
        strobe.memRe   = 1'b1;
        strobe.addrPre = 1'b1;
        strobe.spDec   = 1'b1;
        strobe.capHi   = 1'b1;
        nextState      = ST_RESTORE;
      end
      ST_RESTORE: begin
        strobe.restore = 1'b1;
        strobe.loadOut = 1'b1;
        nextState      = ST_IDLE;
      end
      default: nextState = ST_IDLE;
    endcase
  end

  assign busy = (state != ST_IDLE);
  assign done = strobe.loadOut;

endmodule

// File: rtl/irq_ctx_datapath.sv
module irq_ctx_datapath
  import irq_ctx_pkg::*;
#(
  parameter int PC_W     = 23,
  parameter int WORD_W   = 16,
  parameter int SP_W     = 16,
  parameter int STAT_W   = 8,
  parameter int PRIO_W   = 3,
  parameter int PRIO_LSB = 5,
  parameter logic [SP_W-1:0] SP_INIT = '0
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           strobe,
  input  logic [PRIO_W-1:0] entryLevel,
  input  logic [PC_W-1:0]   entryVector,
  input  logic [PC_W-1:0]   curPc,
  input  logic [STAT_W-1:0] curStatus,
  input  logic              trapIn,
  input  logic [WORD_W-1:0] memRdata,
  output logic [SP_W-1:0]   memAddr,
  output logic [WORD_W-1:0] memWdata,
  output logic [SP_W-1:0]   spValue,
  output logic [PC_W-1:0]   ctxPc,
  output logic [STAT_W-1:0] ctxStatus,
  output logic              ctxTrap
);

  localparam int PC_HI_W = PC_W - WORD_W;
  localparam logic [SP_W-1:0] STEP = SP_W'(WORD_W / 8);

  logic [SP_W-1:0]   spReg;
  logic [PC_W-1:0]   pcHold;
  logic [PC_W-1:0]   vecHold;
  logic [STAT_W-1:0] statHold;
  logic [PRIO_W-1:0] lvlHold;
  logic              trapHold;
  logic [WORD_W-1:0] hiWord;
  logic [STAT_W-1:0] raisedStat;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      spReg <= SP_INIT;
    end else if (strobe.spInc) begin
      spReg <= spReg + STEP;
    end else if (strobe.spDec) begin
      spReg <= spReg - STEP;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pcHold   <= '0;
      vecHold  <= '0;
      statHold <= '0;
      lvlHold  <= '0;
      trapHold <= 1'b0;
    end else if (strobe.capEntry) begin
      pcHold   <= curPc;
      vecHold  <= entryVector;
      statHold <= curStatus;
      lvlHold  <= entryLevel;
      trapHold <= trapIn;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN)             hiWord <= '0;
    else if (strobe.capHi) hiWord <= memRdata;
  end

  assign memAddr = strobe.addrPre ? (spReg - STEP) : spReg;
  assign spValue = spReg;

  always_comb begin
    if (strobe.wrHi) memWdata = {statHold, trapHold, pcHold[PC_W-1 -: PC_HI_W]};
    else             memWdata = pcHold[WORD_W-1:0];
  end

  always_comb begin
    raisedStat = statHold;
    raisedStat[PRIO_LSB +: PRIO_W] = lvlHold;
  end

  always_comb begin
    if (strobe.restore) begin
      ctxPc     = {hiWord[PC_HI_W-1:0], memRdata};
      ctxStatus = hiWord[WORD_W-1 -: STAT_W];
      ctxTrap   = hiWord[PC_HI_W];
    end else begin
      ctxPc     = vecHold;
      ctxStatus = raisedStat;
      ctxTrap   = 1'b0;
    end
  end

endmodule

// File: rtl/irq_ctx_stacker.sv
module irq_ctx_stacker
  import irq_ctx_pkg::*;
#(
  parameter int PC_W     = 23,
  parameter int WORD_W   = 16,
  parameter int SP_W     = 16,
  parameter int STAT_W   = 8,
  parameter int PRIO_W   = 3,
  parameter int PRIO_LSB = 5,
  parameter logic [SP_W-1:0] SP_INIT = 16'h0400
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              entryReq,
  input  logic [PRIO_W-1:0] entryLevel,
  input  logic [PC_W-1:0]   entryVector,
  input  logic              retReq,
  input  logic [PC_W-1:0]   curPc,
  input  logic [STAT_W-1:0] curStatus,
  input  logic              trapIn,
  output logic              memWe,
  output logic              memRe,
  output logic [SP_W-1:0]   memAddr,
  output logic [WORD_W-1:0] memWdata,
  input  logic [WORD_W-1:0] memRdata,
  output logic [SP_W-1:0]   spValue,
  output logic              ctxLoad,
  output logic [PC_W-1:0]   ctxPc,
  output logic [STAT_W-1:0] ctxStatus,
  output logic              ctxTrap,
  output logic              busy,
  output logic              done
);

  strobe_t strobe;

  irq_ctx_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .entryReq (entryReq),
    .retReq   (retReq),
    .strobe   (strobe),
    .busy     (busy),
    .done     (done)
  );

  irq_ctx_datapath #(
    .PC_W     (PC_W),
    .WORD_W   (WORD_W),
    .SP_W     (SP_W),
    .STAT_W   (STAT_W),
    .PRIO_W   (PRIO_W),
    .PRIO_LSB (PRIO_LSB),
    .SP_INIT  (SP_INIT)
  ) u_dp (
    .clk         (clk),
    .rstN        (rstN),
    .strobe      (strobe),
    .entryLevel  (entryLevel),
    .entryVector (entryVector),
    .curPc       (curPc),
    .curStatus   (curStatus),
    .trapIn      (trapIn),
    .memRdata    (memRdata),
    .memAddr     (memAddr),
    .memWdata    (memWdata),
    .spValue     (spValue),
    .ctxPc       (ctxPc),
    .ctxStatus   (ctxStatus),
    .ctxTrap     (ctxTrap)
  );

  assign memWe   = strobe.memWe;
  assign memRe   = strobe.memRe;
  assign ctxLoad = strobe.loadOut;

endmodule

// File: rtl/irq_ctx_stacker_chk.sv
module irq_ctx_stacker_chk #(
  parameter int SP_W = 16
) (
  input logic            clk,
  input logic            rstN,
  input logic            entryReq,
  input logic            retReq,
  input logic            busy,
  input logic            done,
  input logic            memWe,
  input logic            memRe,
  input logic [SP_W-1:0] memAddr,
  input logic [SP_W-1:0] spValue,
  input logic            ctxLoad
);

  AST_NO_RW_OVERLAP: assert property (@(posedge clk) disable iff (!rstN)
    !(memWe && memRe)); // R10

  AST_ENTRY_FIRST_WRITE: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && entryReq) |=> (memWe && memAddr == $past(spValue))); // R2

  AST_SECOND_WRITE_NEXT: assert property (@(posedge clk) disable iff (!rstN)
    $rose(memWe) |=> (memWe && memAddr == $past(memAddr) + SP_W'(2))); // R3

  AST_RETURN_PREDEC: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && retReq && !entryReq) |=> (memRe && memAddr == $past(spValue) - SP_W'(2))); // R6

  AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done); // R5

  AST_LOAD_AT_DONE: assert property (@(posedge clk) disable iff (!rstN)
    ctxLoad |-> (done && busy)); // R7

  AST_BUSY_HOLDS_SP: assert property (@(posedge clk) disable iff (!rstN)
    (busy && !memWe && !memRe) |=> (spValue == $past(spValue))); // R8

endmodule

bind irq_ctx_stacker irq_ctx_stacker_chk #(.SP_W(SP_W)) u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .entryReq (entryReq),
  .retReq   (retReq),
  .busy     (busy),
  .done     (done),
  .memWe    (memWe),
  .memRe    (memRe),
  .memAddr  (memAddr),
  .spValue  (spValue),
  .ctxLoad  (ctxLoad)
);

// File: tb/tb_irq_ctx_stacker.sv
module tb_irq_ctx_stacker;

  localparam logic [15:0] SP0 = 16'h0400;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        entryReq = 1'b0;
  logic [2:0]  entryLevel = '0;
  logic [22:0] entryVector = '0;
  logic        retReq = 1'b0;
  logic [22:0] curPc = '0;
  logic [7:0]  curStatus = '0;
  logic        trapIn = 1'b0;
  logic        memWe, memRe, ctxLoad, ctxTrap, busy, done;
  logic [15:0] memAddr, memWdata, spValue;
  logic [15:0] memRdata = '0;
  logic [22:0] ctxPc;
  logic [7:0]  ctxStatus;

  always #10 clk = ~clk;  // 50 MHz

  irq_ctx_stacker #(.SP_INIT(SP0)) dut (
    .clk(clk), .rstN(rstN), .entryReq(entryReq), .entryLevel(entryLevel),
    .entryVector(entryVector), .retReq(retReq), .curPc(curPc),
    .curStatus(curStatus), .trapIn(trapIn), .memWe(memWe), .memRe(memRe),
    .memAddr(memAddr), .memWdata(memWdata), .memRdata(memRdata),
    .spValue(spValue), .ctxLoad(ctxLoad), .ctxPc(ctxPc),
    .ctxStatus(ctxStatus), .ctxTrap(ctxTrap), .busy(busy), .done(done)
  );

  // data memory with one-cycle read latency
  logic [15:0] ram [0:255];
  always @(posedge clk) begin
    if (memWe) ram[memAddr[8:1]] <= memWdata;
    if (memRe) memRdata <= ram[memAddr[8:1]];
  end

  typedef struct {
    int          kind;   // 0 write, 1 read, 2 load
    logic [15:0] addr;
    logic [15:0] data;
    logic [22:0] pc;
    logic [7:0]  stat;
    logic        trap;
    string       tag;
  } exp_t;

  typedef struct {
    logic [22:0] pc;
    logic [7:0]  stat;
    logic        trap;
  } frame_t;

  exp_t        expQ[$];
  frame_t      frames[$];
  logic [15:0] tbSp = SP0;
  int          compared = 0;
  int          mismatched = 0;

  task automatic check(input bit ok, input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    compared++;
    if (!ok) begin
      mismatched++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  // monitor: one expected item per strobe
  always @(negedge clk) begin
    if (rstN) begin
      if (memWe || memRe)
        check(!(memWe && memRe), "R10", "we/re overlap", {memWe, memRe}, 2'b00);
      if (memWe || memRe || ctxLoad) begin
        if (expQ.size() == 0) begin
          check(1'b0, "R8", "unexpected activity", {memWe, memRe, ctxLoad}, 3'b000);
        end else begin
          exp_t e;
          e = expQ.pop_front();
          if (e.kind == 0) begin
            check(memWe, e.tag, "write strobe", memWe, 1'b1);
            check(memAddr == e.addr, e.tag, "write addr", memAddr, e.addr);
            check(memWdata == e.data, e.tag, "write data", memWdata, e.data);
          end else if (e.kind == 1) begin
            check(memRe, e.tag, "read strobe", memRe, 1'b1);
            check(memAddr == e.addr, e.tag, "read addr", memAddr, e.addr);
          end else begin
            check(ctxLoad, e.tag, "load strobe", ctxLoad, 1'b1);
            check(ctxPc == e.pc, e.tag, "ctx pc", ctxPc, e.pc);
            check(ctxStatus == e.stat, e.tag, "ctx status", ctxStatus, e.stat);
            check(ctxTrap == e.trap, e.tag, "ctx trap", ctxTrap, e.trap);
          end
        end
      end
    end
  end

  task automatic pushExp(input int kind, input logic [15:0] a, input logic [15:0] d,
                         input logic [22:0] pc, input logic [7:0] st, input logic tr,
                         input string tag);
    exp_t e;
    e.kind = kind; e.addr = a; e.data = d; e.pc = pc; e.stat = st; e.trap = tr; e.tag = tag;
    expQ.push_back(e);
  endtask

  // noise: hold both requests high while busy (R8); both: retReq with entryReq (R9)
  task automatic doEntry(input logic [22:0] pc, input logic [7:0] st, input logic tr,
                         input logic [2:0] lvl, input logic [22:0] vec,
                         input bit noise, input bit both);
    frame_t f;
    logic [7:0] raised;
    raised = (st & 8'h1F) | {lvl, 5'b0};
    pushExp(0, tbSp, pc[15:0], '0, '0, 1'b0, "R2");
    pushExp(0, tbSp + 16'd2, {st, tr, pc[22:16]}, '0, '0, 1'b0, "R3");
    pushExp(2, '0, '0, vec, raised, 1'b0, "R5");
    f.pc = pc; f.stat = st; f.trap = tr;
    frames.push_back(f);
    tbSp = tbSp + 16'd4;
    @(negedge clk);
    curPc = pc; curStatus = st; trapIn = tr; entryLevel = lvl; entryVector = vec;
    entryReq = 1'b1; retReq = both;
    @(negedge clk);  // PUSH_LO
    entryReq = noise; retReq = noise;
    curPc = ~pc; curStatus = ~st; entryVector = ~vec;
    @(negedge clk);  // PUSH_HI
    @(negedge clk);  // LOAD_VEC
    entryReq = 1'b0; retReq = 1'b0;
    check(done == 1'b1, "R5", "done at third cycle", done, 1'b1);
    @(negedge clk);  // IDLE
    check(done == 1'b0, "R5", "done one cycle", done, 1'b0);
    check(spValue == tbSp, noise ? "R8" : (both ? "R9" : "R4"), "sp after entry", spValue, tbSp);
    check(busy == 1'b0, "R8", "idle after entry", busy, 1'b0);
  endtask

  task automatic doReturn(input bit noise);
    frame_t f;
    f = frames.pop_back();
    pushExp(1, tbSp - 16'd2, '0, '0, '0, 1'b0, "R6");
    pushExp(1, tbSp - 16'd4, '0, '0, '0, 1'b0, "R6");
    pushExp(2, '0, '0, f.pc, f.stat, f.trap, "R7");
    tbSp = tbSp - 16'd4;
    @(negedge clk);
    retReq = 1'b1;
    @(negedge clk);  // POP_HI
    retReq = noise; entryReq = noise;
    @(negedge clk);  // POP_LO
    @(negedge clk);  // RESTORE
    retReq = 1'b0; entryReq = 1'b0;
    check(done == 1'b1, "R7", "done at third cycle", done, 1'b1);
    @(negedge clk);
    check(spValue == tbSp, "R6", "sp after return", spValue, tbSp);
    check(busy == 1'b0, "R8", "idle after return", busy, 1'b0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    check(busy == 1'b0 && done == 1'b0, "R1", "busy/done", {busy, done}, 2'b00);
    check(!memWe && !memRe && !ctxLoad, "R1", "strobes", {memWe, memRe, ctxLoad}, 3'b000);
    check(spValue == SP0, "R1", "sp reset", spValue, SP0);

    doEntry(23'h5A1234, 8'h21, 1'b0, 3'd3, 23'h000100, 1'b0, 1'b0);
    doEntry(23'h7F00FF, 8'h6E, 1'b1, 3'd5, 23'h000200, 1'b1, 1'b0);  // R8 noise
    doReturn(1'b1);                                                   // R7 inner frame
    doEntry(23'h012345, 8'hFF, 1'b1, 3'd1, 23'h400004, 1'b0, 1'b1);  // R9 both
    doReturn(1'b0);
    doReturn(1'b0);                                                   // R7 outer frame
    repeat (3) @(negedge clk);
    check(expQ.size() == 0, "R8", "pending items", expQ.size(), 0);
    check(spValue == SP0, "R4", "sp back to start", spValue, SP0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    mismatched++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

endmodule